// File: doc/BRIEF.md
# Fetch Branch Predictor with Return Stack

This block predicts the next fetch address for an instruction fetch unit. Each cycle the fetch unit offers the PC of the previous fetch, and a direct-mapped target table answers in the same cycle. The answer is a hit flag, a taken/not-taken guess from a two-bit saturating counter, and a predicted target. A four-deep return stack sits beside the table. The decode stage reads the top of that stack when it finds a return instruction and uses it as the return target.

Only the commit port changes predictor state. It reports resolved branches, jumps, calls and returns. A call pushes its link address onto the return stack and a return pops it. Every reported instruction trains the target table. Because the table is indexed by the previous fetch PC and not by decoded bits, the guess can land on a slot that is not a branch, or on the wrong 32/16-bit boundary. Decode reports such cases, and the block then issues a redirect to the recovered PC.

The block has three redirect sources. A bad decode slot and a stack-predicted return each cost 2 cycles. A wrong execute-stage resolution costs 5 cycles. The block issues a one-cycle redirect pulse with a cause code and holds the lookup port's ready low for the penalty length.

The lookup port uses a valid/ready handshake. A lookup is accepted only in a cycle where both `lk_valid` and `lk_ready` are high, and its prediction is returned in that same cycle. The lookup holds no state, so the fetch unit may change `lk_pc` or drop `lk_valid` freely while `lk_ready` is low. While `lk_ready` is low, no lookup is accepted and the prediction outputs read as a miss. The decode, execute and commit ports have no back-pressure. Every report on them is taken in the cycle it is presented.

Top module: `bp_fetch_predictor`

## Requirements
- R1: An accepted lookup indexes the 128-entry table with PC bits [7:1] and compares a stored 26-bit tag field that holds PC bits [31:8] zero-extended. It reports a hit only if the entry is valid and the tag matches. On a miss, `lk_taken` is 0 and `lk_target` is 0.
- R2: A hitting entry predicts taken when its counter is 2 or 3. A committed taken instruction increments the counter, saturating at 3. A committed not-taken branch decrements it, saturating at 0. A taken instruction that misses allocates its entry with counter 2. A not-taken branch that misses allocates nothing.
- R3: A committed taken instruction writes its target into the entry. Jumps, calls and returns (`cm_kind` 1, 2, 3) always count as taken, and branches (`cm_kind` 0) follow `cm_taken`. Table writes appear only from the next cycle, so a lookup in the same cycle as a commit to the same entry sees the old contents.
- R4: A committed call pushes `cm_link_pc` and a committed return pops. The stack holds 4 addresses, and a push onto a full stack discards the oldest. A pop on an empty stack does nothing. `dc_ras_valid` and `dc_ras_target` show the current top without popping it.
- R5: A decode report with `dc_pred_taken` set and either `dc_is_branch` low or `dc_bound_ok` low is a slot misprediction. In the next cycle it gives `redir_valid` with `redir_pc` equal to `dc_seq_pc` and cause 1.
- R6: A decode report with `dc_is_ret` set, a non-empty stack and no slot misprediction gives a redirect in the next cycle to the stack top, with cause 2. With an empty stack it gives no redirect.
- R7: An execute report mispredicts when the resolved direction differs from the predicted one, or when both are taken with different targets. The block then redirects in the next cycle with cause 3, to `ex_target` if the branch was taken and otherwise to `ex_fall_pc`.
- R8: When more than one source fires, an execute misprediction wins over any decode event. Decode events are ignored in every cycle where `lk_ready` is low. `redir_valid` never carries cause 0.
- R9: After a redirect, `lk_ready` is low for exactly the penalty of its cause (2, 2 or 5 cycles), starting in the cycle `redir_valid` is high. A new execute redirect restarts the count. `lk_hit` is 0 whenever `lk_ready` is low.
- R10: Out of reset, all table entries are invalid, the stack is empty, `lk_ready` is 1 and `redir_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted; low during recovery penalty |
| lk_pc | input | 32 | Previous fetch PC used as lookup key |
| lk_hit | output | 1 | Accepted lookup matched a valid entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted target (0 on miss) |
| dc_valid | input | 1 | Decode report valid |
| dc_pred_taken | input | 1 | Fetch followed a taken guess for this slot |
| dc_is_branch | input | 1 | Slot decodes as branch or jump |
| dc_bound_ok | input | 1 | Predicted 32/16-bit boundary was correct |
| dc_is_ret | input | 1 | Slot decodes as a return |
| dc_seq_pc | input | 32 | Recovered sequential PC for a slot misprediction |
| dc_ras_valid | output | 1 | Return stack is non-empty |
| dc_ras_target | output | 32 | Return stack top |
| ex_valid | input | 1 | Execute resolution valid |
| ex_pred_taken | input | 1 | Direction that was predicted |
| ex_pred_target | input | 32 | Target that was predicted |
| ex_taken | input | 1 | Resolved direction |
| ex_target | input | 32 | Resolved target |
| ex_fall_pc | input | 32 | Fall-through PC |
| cm_valid | input | 1 | Commit report valid |
| cm_kind | input | 2 | 0 branch, 1 jump, 2 call, 3 return |
| cm_pc | input | 32 | PC used to index and tag the entry |
| cm_taken | input | 1 | Resolved direction of a branch |
| cm_target | input | 32 | Resolved target |
| cm_link_pc | input | 32 | Return address pushed by a call |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect address |
| redir_cause | output | 2 | 1 slot, 2 return, 3 execute |

## Verification
Two pairs of functions can act in the same cycle, and the bench provokes both. The first pair is redirect arbitration. The bench drives an execute misprediction together with a decode slot misprediction or a stack-predicted return, and it also raises an execute event while a 2-cycle decode penalty is still counting. In those cases the redirect must carry cause 3 and the 5-cycle stall must restart. The second pair is a commit that writes an entry, or pushes to or pops from the stack, in the same cycle as a lookup or a decode return read of that state. Such a read must see the old contents. A behavioural model in the bench judges both pairs every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    K_BRANCH = 2'd0,
    K_JUMP   = 2'd1,
    K_CALL   = 2'd2,
    K_RET    = 2'd3
  } cm_kind_e;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_SLOT = 2'd1,
    RC_RET  = 2'd2,
    RC_EXEC = 2'd3
  } redir_cause_e;
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 26,
  parameter int CNT_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic            rd_taken,
  output logic [PC_W-1:0] rd_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int IDX_LO      = 1;
  localparam int TAG_LO      = IDX_LO + IDX_W;
  localparam int PC_TAG_BITS = PC_W - TAG_LO;
  localparam int USE_TAG     = (TAG_W < PC_TAG_BITS) ? TAG_W : PC_TAG_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    logic [TAG_W-1:0] t;
    t = '0;
    t[USE_TAG-1:0] = pc[TAG_LO +: USE_TAG];
    return t;
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx;
  logic             rd_match;

  assign rd_idx   = rd_pc[IDX_LO +: IDX_W];
  assign rd_match = vld_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc));

  always_comb begin
    rd_hit    = rd_en && rd_match;
    rd_taken  = rd_hit && cnt_q[rd_idx][CNT_W-1];
    rd_target = rd_hit ? tgt_q[rd_idx] : '0;
  end

  logic [IDX_W-1:0] up_idx;
  logic             up_match;
  logic [CNT_W-1:0] up_cur;
  logic [CNT_W-1:0] up_next;
  logic             up_wr;

  assign up_idx   = upd_pc[IDX_LO +: IDX_W];
  assign up_match = vld_q[up_idx] && (tag_q[up_idx] == tag_of(upd_pc));
  assign up_cur   = cnt_q[up_idx];

  always_comb begin
    up_wr   = upd_en && (up_match || upd_taken);
    up_next = CNT_INIT;
    if (up_match) begin
      if (upd_taken) begin
        up_next = (up_cur == CNT_MAX) ? up_cur : up_cur + CNT_W'(1);
      end else begin
        up_next = (up_cur == '0) ? up_cur : up_cur - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (up_wr) begin
      vld_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_wr) begin
      tag_q[up_idx] <= tag_of(upd_pc);
      cnt_q[up_idx] <= up_next;
      if (upd_taken) begin
        tgt_q[up_idx] <= upd_target;
      end
    end
  end

  logic unused_pc_lsb;
  assign unused_pc_lsb = rd_pc[0] ^ upd_pc[0];
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop_en,
  output logic            top_valid,
  output logic [PC_W-1:0] top_addr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] top_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] push_ptr;
  logic [PTR_W-1:0] pop_ptr;
  logic [PC_W-1:0]  slot_q [DEPTH];

  assign push_ptr = (top_q == PTR_LAST) ? '0 : top_q + PTR_W'(1);
  assign pop_ptr  = (top_q == '0) ? PTR_LAST : top_q - PTR_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_en && (push_ptr == PTR_W'(g))) begin
        slot_q[g] <= push_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= PTR_LAST;
      cnt_q <= '0;
    end else if (push_en) begin
      top_q <= push_ptr;
      cnt_q <= (cnt_q == CNT_FULL) ? cnt_q : cnt_q + CNT_W'(1);
    end else if (pop_en && (cnt_q != '0)) begin
      top_q <= pop_ptr;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign top_valid = (cnt_q != '0);
  assign top_addr  = slot_q[top_q];
endmodule

// File: rtl/bp_recover.sv
module bp_recover
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int SLOT_PEN = 2,
  parameter int RET_PEN  = 2,
  parameter int EXEC_PEN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dc_valid,
  input  logic            dc_pred_taken,
  input  logic            dc_is_branch,
  input  logic            dc_bound_ok,
  input  logic            dc_is_ret,
  input  logic [PC_W-1:0] dc_seq_pc,
  input  logic            ras_valid,
  input  logic [PC_W-1:0] ras_addr,
  input  logic            ex_valid,
  input  logic            ex_pred_taken,
  input  logic [PC_W-1:0] ex_pred_target,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic [PC_W-1:0] ex_fall_pc,
  output logic            fetch_open,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output redir_cause_e    redir_cause
);
  localparam int PEN_A   = (SLOT_PEN > RET_PEN) ? SLOT_PEN : RET_PEN;
  localparam int PEN_MAX = (EXEC_PEN > PEN_A) ? EXEC_PEN : PEN_A;
  localparam int PCNT_W  = $clog2(PEN_MAX + 1);

  logic [PCNT_W-1:0] pcnt_q;
  logic              ex_mis;
  logic              slot_mis;
  logic              ret_go;
  logic              ev;
  logic [PC_W-1:0]   ev_pc;
  redir_cause_e      ev_cause;
  logic [PCNT_W-1:0] ev_pen;

  assign fetch_open = (pcnt_q == '0);

  always_comb begin
    ex_mis   = ex_valid && ((ex_taken != ex_pred_taken) ||
                            (ex_taken && (ex_target != ex_pred_target)));
    slot_mis = fetch_open && dc_valid && dc_pred_taken &&
               (!dc_is_branch || !dc_bound_ok);
    ret_go   = fetch_open && dc_valid && dc_is_ret && ras_valid && !slot_mis;
    ev       = 1'b1;
    ev_pc    = '0;
    ev_cause = RC_NONE;
    ev_pen   = '0;
    if (ex_mis) begin
      ev_pc    = ex_taken ? ex_target : ex_fall_pc;
      ev_cause = RC_EXEC;
      ev_pen   = PCNT_W'(EXEC_PEN);
    end else if (slot_mis) begin
      ev_pc    = dc_seq_pc;
      ev_cause = RC_SLOT;
      ev_pen   = PCNT_W'(SLOT_PEN);
    end else if (ret_go) begin
      ev_pc    = ras_addr;
      ev_cause = RC_RET;
      ev_pen   = PCNT_W'(RET_PEN);
    end else begin
      ev       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q      <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_cause <= RC_NONE;
    end else begin
      redir_valid <= ev;
      if (ev) begin
        pcnt_q      <= ev_pen;
        redir_pc    <= ev_pc;
        redir_cause <= ev_cause;
      end else if (pcnt_q != '0) begin
        pcnt_q      <= pcnt_q - PCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 128,
  parameter int TAG_W     = 26,
  parameter int CNT_W     = 2,
  parameter int RAS_DEPTH = 4,
  parameter int SLOT_PEN  = 2,
  parameter int RET_PEN   = 2,
  parameter int EXEC_PEN  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            dc_valid,
  input  logic            dc_pred_taken,
  input  logic            dc_is_branch,
  input  logic            dc_bound_ok,
  input  logic            dc_is_ret,
  input  logic [PC_W-1:0] dc_seq_pc,
  output logic            dc_ras_valid,
  output logic [PC_W-1:0] dc_ras_target,
  input  logic            ex_valid,
  input  logic            ex_pred_taken,
  input  logic [PC_W-1:0] ex_pred_target,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic [PC_W-1:0] ex_fall_pc,
  input  logic            cm_valid,
  input  logic [1:0]      cm_kind,
  input  logic [PC_W-1:0] cm_pc,
  input  logic            cm_taken,
  input  logic [PC_W-1:0] cm_target,
  input  logic [PC_W-1:0] cm_link_pc,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output logic [1:0]      redir_cause
);
  cm_kind_e     kind;
  redir_cause_e cause_w;
  logic         open_w;
  logic         eff_taken;

  assign kind      = cm_kind_e'(cm_kind);
  assign eff_taken = cm_taken || (kind != K_BRANCH);
  assign lk_ready  = open_w;

  bp_btb #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_btb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (lk_valid && open_w),
    .rd_pc      (lk_pc),
    .rd_hit     (lk_hit),
    .rd_taken   (lk_taken),
    .rd_target  (lk_target),
    .upd_en     (cm_valid),
    .upd_pc     (cm_pc),
    .upd_taken  (eff_taken),
    .upd_target (cm_target)
  );

  bp_ras #(
    .PC_W(PC_W), .DEPTH(RAS_DEPTH)
  ) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (cm_valid && (kind == K_CALL)),
    .push_addr (cm_link_pc),
    .pop_en    (cm_valid && (kind == K_RET)),
    .top_valid (dc_ras_valid),
    .top_addr  (dc_ras_target)
  );

  bp_recover #(
    .PC_W(PC_W), .SLOT_PEN(SLOT_PEN), .RET_PEN(RET_PEN), .EXEC_PEN(EXEC_PEN)
  ) u_rec (
    .clk            (clk),
    .rst_n          (rst_n),
    .dc_valid       (dc_valid),
    .dc_pred_taken  (dc_pred_taken),
    .dc_is_branch   (dc_is_branch),
    .dc_bound_ok    (dc_bound_ok),
    .dc_is_ret      (dc_is_ret),
    .dc_seq_pc      (dc_seq_pc),
    .ras_valid      (dc_ras_valid),
    .ras_addr       (dc_ras_target),
    .ex_valid       (ex_valid),
    .ex_pred_taken  (ex_pred_taken),
    .ex_pred_target (ex_pred_target),
    .ex_taken       (ex_taken),
    .ex_target      (ex_target),
    .ex_fall_pc     (ex_fall_pc),
    .fetch_open     (open_w),
    .redir_valid    (redir_valid),
    .redir_pc       (redir_pc),
    .redir_cause    (cause_w)
  );

  assign redir_cause = cause_w;
endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       lk_ready,
  input logic       lk_hit,
  input logic       lk_taken,
  input logic       dc_ras_valid,
  input logic       ex_valid,
  input logic       ex_pred_taken,
  input logic       ex_taken,
  input logic       cm_valid,
  input logic [1:0] cm_kind,
  input logic       redir_valid,
  input logic [1:0] redir_cause
);
  assert_no_hit_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_ready || !lk_valid) |-> !lk_hit);

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);

  assert_call_fills_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_kind == 2'd2) |=> dc_ras_valid);

  assert_exec_dir_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_taken != ex_pred_taken)) |=> (redir_valid && redir_cause == 2'd3));

  assert_redirect_blocks_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !lk_ready);

  assert_penalty_outlasts_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !lk_ready);

  assert_cause_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_cause != 2'd0));
endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .lk_hit       (lk_hit),
  .lk_taken     (lk_taken),
  .dc_ras_valid (dc_ras_valid),
  .ex_valid     (ex_valid),
  .ex_pred_taken(ex_pred_taken),
  .ex_taken     (ex_taken),
  .cm_valid     (cm_valid),
  .cm_kind      (cm_kind),
  .redir_valid  (redir_valid),
  .redir_cause  (redir_cause)
);

// File: tb/sim_bp_fetch_predictor.sv
module sim_bp_fetch_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid, lk_ready, lk_hit, lk_taken;
  logic [31:0] lk_pc, lk_target;
  logic        dc_valid, dc_pred_taken, dc_is_branch, dc_bound_ok, dc_is_ret;
  logic [31:0] dc_seq_pc;
  logic        dc_ras_valid;
  logic [31:0] dc_ras_target;
  logic        ex_valid, ex_pred_taken, ex_taken;
  logic [31:0] ex_pred_target, ex_target, ex_fall_pc;
  logic        cm_valid, cm_taken;
  logic [1:0]  cm_kind;
  logic [31:0] cm_pc, cm_target, cm_link_pc;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic [1:0]  redir_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_fetch_predictor u0 (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_vld [128];
  logic [31:0] m_tag [128];
  logic [31:0] m_tgt [128];
  int          m_cnt [128];
  logic [31:0] m_stk [$];
  int          m_pen = 0;
  bit          e_rv = 0;
  logic [31:0] e_rpc = 0;
  int          e_rc = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string cause_tag(int c);
    case (c)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic clear_inputs();
    lk_valid = 0; lk_pc = 0;
    dc_valid = 0; dc_pred_taken = 0; dc_is_branch = 0; dc_bound_ok = 1;
    dc_is_ret = 0; dc_seq_pc = 0;
    ex_valid = 0; ex_pred_taken = 0; ex_taken = 0;
    ex_pred_target = 0; ex_target = 0; ex_fall_pc = 0;
    cm_valid = 0; cm_kind = 0; cm_pc = 0; cm_taken = 0; cm_target = 0; cm_link_pc = 0;
  endtask

  task automatic compare();
    bit acc, hit, tk;
    logic [31:0] tg;
    int ix;
    acc = lk_valid && (m_pen == 0);
    ix  = int'(lk_pc[7:1]);
    hit = acc && m_vld[ix] && (m_tag[ix] == {8'h0, lk_pc[31:8]});
    tk  = hit && (m_cnt[ix] >= 2);
    tg  = hit ? m_tgt[ix] : 32'h0;
    chk("R9", "lk_ready", {31'h0, lk_ready}, {31'h0, m_pen == 0});
    chk("R1", "lk_hit", {31'h0, lk_hit}, {31'h0, hit});
    chk("R2", "lk_taken", {31'h0, lk_taken}, {31'h0, tk});
    chk("R3", "lk_target", lk_target, tg);
    chk("R4", "ras_valid", {31'h0, dc_ras_valid}, {31'h0, m_stk.size() > 0});
    if (m_stk.size() > 0) chk("R4", "ras_target", dc_ras_target, m_stk[$]);
    chk(cause_tag(e_rc), "redir_valid", {31'h0, redir_valid}, {31'h0, e_rv});
    if (e_rv) begin
      chk(cause_tag(e_rc), "redir_cause", {30'h0, redir_cause}, e_rc[31:0]);
      chk(cause_tag(e_rc), "redir_pc", redir_pc, e_rpc);
    end
  endtask

  task automatic advance();
    bit open, exm, slot, ret, et, h;
    int ix;
    open = (m_pen == 0);
    exm  = ex_valid && ((ex_taken != ex_pred_taken) || (ex_taken && ex_target != ex_pred_target));
    slot = open && dc_valid && dc_pred_taken && (!dc_is_branch || !dc_bound_ok);
    ret  = open && dc_valid && dc_is_ret && (m_stk.size() > 0) && !slot;
    if (exm) begin
      e_rv = 1; e_rc = 3; e_rpc = ex_taken ? ex_target : ex_fall_pc; m_pen = 5;
    end else if (slot) begin
      e_rv = 1; e_rc = 1; e_rpc = dc_seq_pc; m_pen = 2;
    end else if (ret) begin
      e_rv = 1; e_rc = 2; e_rpc = m_stk[$]; m_pen = 2;
    end else begin
      e_rv = 0;
      if (m_pen > 0) m_pen--;
    end
    if (cm_valid) begin
      et = cm_taken || (cm_kind != 2'd0);
      ix = int'(cm_pc[7:1]);
      h  = m_vld[ix] && (m_tag[ix] == {8'h0, cm_pc[31:8]});
      if (h) begin
        if (et) begin
          if (m_cnt[ix] < 3) m_cnt[ix]++;
          m_tgt[ix] = cm_target;
        end else if (m_cnt[ix] > 0) m_cnt[ix]--;
      end else if (et) begin
        m_vld[ix] = 1; m_tag[ix] = {8'h0, cm_pc[31:8]}; m_cnt[ix] = 2; m_tgt[ix] = cm_target;
      end
      if (cm_kind == 2'd2) begin
        m_stk.push_back(cm_link_pc);
        if (m_stk.size() > 4) void'(m_stk.pop_front());
      end else if (cm_kind == 2'd3) begin
        if (m_stk.size() > 0) void'(m_stk.pop_back());
      end
    end
  endtask

  // inputs are set at the falling edge; compare, then model the rising edge
  task automatic step();
    #1;
    compare();
    advance();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic look(logic [31:0] pc);
    lk_valid = 1; lk_pc = pc;
  endtask

  task automatic commit(logic [1:0] k, logic [31:0] pc, bit t, logic [31:0] tgt, logic [31:0] link);
    cm_valid = 1; cm_kind = k; cm_pc = pc; cm_taken = t; cm_target = tgt; cm_link_pc = link;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      look(32'h1000);
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_vld[i] = 0; m_cnt[i] = 0; m_tag[i] = 0; m_tgt[i] = 0;
    end
    clear_inputs();
    lk_valid = 1; lk_pc = 32'h1000;
    repeat (3) @(negedge clk);
    // R10: reset state seen at the ports
    chk("R10", "reset lk_ready", {31'h0, lk_ready}, 32'h1);
    chk("R10", "reset redir_valid", {31'h0, redir_valid}, 32'h0);
    chk("R10", "reset ras_valid", {31'h0, dc_ras_valid}, 32'h0);
    chk("R10", "reset lk_hit", {31'h0, lk_hit}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    clear_inputs();

    // R1 miss, then R3 commit and lookup to the same entry in the same cycle
    look(32'h1000); step();
    look(32'h1000); commit(2'd0, 32'h1000, 1, 32'h2000, 0); step();
    look(32'h1000); step();
    // R2 counter walk down and saturation at 0
    for (int i = 0; i < 3; i++) begin
      look(32'h1000); commit(2'd0, 32'h1000, 0, 0, 0); step();
    end
    // R2 walk up and saturation at 3, target rewrite R3
    for (int i = 0; i < 4; i++) begin
      look(32'h1000); commit(2'd0, 32'h1000, 1, 32'h2400 + i*4, 0); step();
    end
    look(32'h1000); step();
    // R1 alias with different tag
    look(32'h1100); step();
    // R2 not-taken miss allocates nothing
    commit(2'd0, 32'h3000, 0, 32'h5000, 0); step();
    look(32'h3000); step();
    // R3 jump counts as taken
    commit(2'd1, 32'h3004, 0, 32'h4000, 0); step();
    look(32'h3004); step();
    // R4 five calls overflow the stack
    for (int i = 1; i <= 5; i++) begin
      commit(2'd2, 32'h6000 + i*2, 0, 32'h7000, 32'h100 * i); step();
    end
    // R6 decode return redirects to stack top; R8 decode ignored in stall
    dc_valid = 1; dc_is_ret = 1; step();
    dc_valid = 1; dc_pred_taken = 1; dc_is_branch = 0; dc_seq_pc = 32'hAAAA; look(32'h1000); step();
    idle(2);
    // R4 pops in the same cycle as a decode return read
    for (int i = 0; i < 5; i++) begin
      commit(2'd3, 32'h6100, 1, 32'h100, 0); step();
    end
    // R6 return with empty stack
    dc_valid = 1; dc_is_ret = 1; step();
    idle(1);
    // R5 non-branch slot, then wrong boundary
    dc_valid = 1; dc_pred_taken = 1; dc_is_branch = 0; dc_seq_pc = 32'h1234; step();
    idle(3);
    dc_valid = 1; dc_pred_taken = 1; dc_is_branch = 1; dc_bound_ok = 0; dc_seq_pc = 32'h1236; step();
    idle(3);
    // R7 correct prediction, wrong direction, wrong target
    ex_valid = 1; ex_pred_taken = 1; ex_taken = 1; ex_pred_target = 32'h88; ex_target = 32'h88; step();
    ex_valid = 1; ex_pred_taken = 1; ex_taken = 0; ex_fall_pc = 32'h9004; step();
    idle(6);
    ex_valid = 1; ex_pred_taken = 1; ex_taken = 1; ex_pred_target = 32'h80; ex_target = 32'h90; step();
    idle(6);
    // R8 execute and decode events together
    commit(2'd2, 32'h6002, 0, 32'h7000, 32'h500); step();
    ex_valid = 1; ex_pred_taken = 0; ex_taken = 1; ex_target = 32'hB000;
    dc_valid = 1; dc_is_ret = 1; step();
    idle(6);
    // R9 execute redirect restarts a decode penalty
    dc_valid = 1; dc_pred_taken = 1; dc_seq_pc = 32'hC000; step();
    ex_valid = 1; ex_pred_taken = 1; ex_taken = 0; ex_fall_pc = 32'hC100; look(32'h1000); step();
    idle(7);

    // mixed traffic over a small PC pool
    for (int i = 0; i < 400; i++) begin
      look(32'h1000 + ($urandom % 8) * 2 + ($urandom % 2) * 32'h100);
      lk_valid = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) begin
        commit(2'($urandom % 4), 32'h1000 + ($urandom % 8) * 2 + ($urandom % 2) * 32'h100,
               1'($urandom % 2), 32'h2000 + ($urandom % 16) * 4, 32'h3000 + i * 4);
      end
      if ($urandom % 5 == 0) begin
        dc_valid = 1; dc_pred_taken = 1'($urandom % 2); dc_is_branch = 1'($urandom % 2);
        dc_bound_ok = 1'($urandom % 2); dc_is_ret = 1'($urandom % 2); dc_seq_pc = 32'h4000 + i * 2;
      end
      if ($urandom % 9 == 0) begin
        ex_valid = 1; ex_pred_taken = 1'($urandom % 2); ex_taken = 1'($urandom % 2);
        ex_pred_target = 32'h80 + ($urandom % 2) * 4; ex_target = 32'h80 + ($urandom % 2) * 4;
        ex_fall_pc = 32'h5000 + i * 2;
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule